// File: doc/BRIEF.md
# Interrupt Vectoring and Arming Controller

This block sits beside a small 4-bit processor core. It collects one non-maskable request and fifteen maskable hardware requests. It latches each request on its rising edge and chooses one pending request. It then presents the program address the core must branch to, and it holds that request until the core acknowledges it. The block also gives the fixed start address that the core fetches from after reset.

The block owns the two stack-pointer registers of the core: a wide one used for 16-bit stack traffic and a narrow one used for 4-bit stack traffic. Each write is trimmed to the wrap range of its pointer. Interrupt delivery, the non-maskable request included, stays off until both pointers have been loaded. After that, loading only one pointer turns delivery off again until the other pointer is loaded too. Requests that arrive while delivery is off stay latched and are delivered once both pointers are set.

Top module: `irq_vector_ctrl`

## Requirements
- R1: During and right after reset, `reset_pc` reads 0x0110, `int_valid` and `armed` are 0, and both stack-pointer outputs read 0.
- R2: `armed` goes to 1 only once both stack pointers have been written since reset, in either order or in the same cycle. While `armed` is 0, `int_valid` stays 0 even when requests are pending.
- R3: While armed, a write to one pointer alone clears `armed`. It stays clear, even across further writes to that same pointer, until the other pointer is written. A write to both in the same cycle keeps the block armed.
- R4: A write to the wide pointer stores the data ANDed with 0x07FF. A write to the narrow pointer stores the data ANDed with 0x00FF. Each result shows on `sp_wide` or `sp_narrow` one cycle after the write.
- R5: A request becomes pending on a 0-to-1 transition of its input. A level that stays high after it has been acknowledged does not make the request pending again.
- R6: When armed and the non-maskable request is pending, `int_valid` is 1 and `int_vector` is 0x0100, whatever maskable requests are pending.
- R7: Maskable input `irq_req[i]` (i = 0 to 14) vectors to 0x0101 + i. When several are pending, the lowest index is presented.
- R8: When `gie` is 0, maskable requests are not presented, though they stay pending. The non-maskable request is still presented.
- R9: `int_ack` high while `int_valid` is 1 clears only the request shown on `int_vector`, at the next clock edge. Other pending requests remain pending.
- R10: A request that becomes pending while disarmed is kept, and it is presented as soon as arming completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| nmi_req | input | 1 | Non-maskable request (watchdog) |
| irq_req | input | 15 | Maskable requests; bit i vectors to 0x0101 + i |
| gie | input | 1 | Global enable for maskable requests |
| sp_wide_we | input | 1 | Write strobe for the wide stack pointer |
| sp_wide_wdata | input | 16 | Write data for the wide stack pointer |
| sp_narrow_we | input | 1 | Write strobe for the narrow stack pointer |
| sp_narrow_wdata | input | 16 | Write data for the narrow stack pointer |
| int_ack | input | 1 | Core acknowledge of the presented vector |
| sp_wide | output | 16 | Current wide stack pointer |
| sp_narrow | output | 16 | Current narrow stack pointer |
| armed | output | 1 | Interrupt delivery is allowed |
| int_valid | output | 1 | A request is being presented |
| int_vector | output | 16 | Branch address for the presented request |
| reset_pc | output | 16 | Program start address after reset |

## Verification
Every result in this block is due exactly one clock edge after its cause. A rising request edge is visible on `int_valid` and `int_vector` after one edge. So are a pointer write on `armed` and the pointer outputs, and an acknowledge on the next presented vector. A change of `gie` acts on the outputs combinationally, with no edge. The bench drives inputs and reads outputs 2 ns after a rising edge. Each check follows a single-edge step, so each result is read in the first settled window after the edge that makes it. The maskable sources are swept one at a time, in every ordered pair, and each one against the non-maskable request, and the expected vector is computed as 0x0101 plus the index.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int NSRC = 15,
  parameter int AW = 16,
  parameter logic [AW-1:0] VEC_BASE = 16'h0100,
  parameter logic [AW-1:0] START_PC = 16'h0110,
  parameter logic [AW-1:0] WIDE_MASK = 16'h07FF,
  parameter logic [AW-1:0] NARROW_MASK = 16'h00FF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            nmi_req,
  input  logic [NSRC-1:0] irq_req,
  input  logic            gie,
  input  logic            sp_wide_we,
  input  logic [AW-1:0]   sp_wide_wdata,
  input  logic            sp_narrow_we,
  input  logic [AW-1:0]   sp_narrow_wdata,
  input  logic            int_ack,
  output logic [AW-1:0]   sp_wide,
  output logic [AW-1:0]   sp_narrow,
  output logic            armed,
  output logic            int_valid,
  output logic [AW-1:0]   int_vector,
  output logic [AW-1:0]   reset_pc
);

  localparam int SW = $clog2(NSRC + 1);

  logic            wide_set, narrow_set;
  logic            nmi_q, nmi_pend;
  logic [NSRC-1:0] irq_q, irq_pend;
  logic [SW-1:0]   sel_idx;
  logic            sel_hit;
  logic            nmi_take, irq_take;
  logic            nmi_clr;
  logic [NSRC-1:0] irq_clr;

  assign reset_pc = START_PC;
  assign armed    = wide_set & narrow_set;

  // stack pointers and the pairing rule
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_wide    <= '0;
      sp_narrow  <= '0;
      wide_set   <= 1'b0;
      narrow_set <= 1'b0;
    end else begin
      if (sp_wide_we)   sp_wide   <= sp_wide_wdata & WIDE_MASK;
      if (sp_narrow_we) sp_narrow <= sp_narrow_wdata & NARROW_MASK;
      if (sp_wide_we && sp_narrow_we) begin
        wide_set   <= 1'b1;
        narrow_set <= 1'b1;
      end else if (sp_wide_we) begin
        wide_set <= 1'b1;
        if (armed) narrow_set <= 1'b0;
      end else if (sp_narrow_we) begin
        narrow_set <= 1'b1;
        if (armed) wide_set <= 1'b0;
      end
    end
  end

  // lowest pending maskable index
  always_comb begin
    sel_idx = '0;
    sel_hit = 1'b0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (irq_pend[i]) begin
        sel_idx = SW'(i);
        sel_hit = 1'b1;
      end
    end
  end

  assign nmi_take   = armed & nmi_pend;
  assign irq_take   = armed & gie & sel_hit & ~nmi_take;
  assign int_valid  = nmi_take | irq_take;
  assign int_vector = nmi_take ? VEC_BASE
                    : irq_take ? VEC_BASE + AW'(sel_idx) + AW'(1)
                    : '0;

  assign nmi_clr = int_ack & nmi_take;
  assign irq_clr = (int_ack & irq_take) ? (NSRC'(1) << sel_idx) : '0;

  // edge capture and pending state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q    <= 1'b0;
      irq_q    <= '0;
      nmi_pend <= 1'b0;
      irq_pend <= '0;
    end else begin
      nmi_q    <= nmi_req;
      irq_q    <= irq_req;
      nmi_pend <= (nmi_pend & ~nmi_clr) | (nmi_req & ~nmi_q);
      irq_pend <= (irq_pend & ~irq_clr) | (irq_req & ~irq_q);
    end
  end

  AST_ARM_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(sp_wide_we || sp_narrow_we)); // R2

  AST_WIDE_ALONE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && sp_wide_we && !sp_narrow_we) |=> !armed); // R3

  AST_NARROW_ALONE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && sp_narrow_we && !sp_wide_we) |=> !armed); // R3

  AST_WIDE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    sp_wide_we |=> sp_wide == ($past(sp_wide_wdata) & WIDE_MASK)); // R4

  AST_NARROW_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    sp_narrow_we |=> sp_narrow == ($past(sp_narrow_wdata) & NARROW_MASK)); // R4

  AST_VECTOR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    int_valid |-> (int_vector >= VEC_BASE && int_vector <= VEC_BASE + AW'(NSRC))); // R7

  AST_HELD_WHILE_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && nmi_pend) |=> nmi_pend); // R10

  AST_ACK_NMI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && int_valid && int_vector == VEC_BASE && !(nmi_req && !nmi_q))
      |=> !nmi_pend); // R9

endmodule

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nmi_req = 1'b0;
  logic [14:0] irq_req = '0;
  logic        gie = 1'b0;
  logic        sp_wide_we = 1'b0;
  logic [15:0] sp_wide_wdata = '0;
  logic        sp_narrow_we = 1'b0;
  logic [15:0] sp_narrow_wdata = '0;
  logic        int_ack = 1'b0;
  logic [15:0] sp_wide, sp_narrow, int_vector, reset_pc;
  logic        armed, int_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_vector_ctrl i_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .irq_req(irq_req), .gie(gie),
    .sp_wide_we(sp_wide_we), .sp_wide_wdata(sp_wide_wdata),
    .sp_narrow_we(sp_narrow_we), .sp_narrow_wdata(sp_narrow_wdata),
    .int_ack(int_ack), .sp_wide(sp_wide), .sp_narrow(sp_narrow), .armed(armed),
    .int_valid(int_valid), .int_vector(int_vector), .reset_pc(reset_pc)
  );

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ack();
    int_ack = 1'b1;
    step();
    int_ack = 1'b0;
  endtask

  task automatic wr_wide(logic [15:0] d);
    sp_wide_we = 1'b1; sp_wide_wdata = d;
    step();
    sp_wide_we = 1'b0;
  endtask

  task automatic wr_narrow(logic [15:0] d);
    sp_narrow_we = 1'b1; sp_narrow_wdata = d;
    step();
    sp_narrow_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #5;
    chk("R1 reset_pc in reset", reset_pc, 16'h0110);
    chk("R1 valid in reset", int_valid, 0);
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk("R1 reset_pc", reset_pc, 16'h0110);
    chk("R1 armed", armed, 0);
    chk("R1 valid", int_valid, 0);
    chk("R1 sp_wide", sp_wide, 0);
    chk("R1 sp_narrow", sp_narrow, 0);

    // requests while disarmed
    nmi_req = 1'b1; irq_req[3] = 1'b1;
    step();
    chk("R2 no delivery before arming", int_valid, 0);
    wr_wide(16'hFFFF);
    chk("R4 wide mask", sp_wide, 16'h07FF);
    chk("R2 one pointer not enough", armed, 0);
    chk("R2 still no delivery", int_valid, 0);
    gie = 1'b1;
    wr_narrow(16'h01FF);
    chk("R4 narrow mask", sp_narrow, 16'h00FF);
    chk("R2 armed after pair", armed, 1);
    chk("R10 held nmi delivered", int_vector, 16'h0100);
    chk("R6 nmi over irq3 valid", int_valid, 1);
    ack();
    chk("R9 irq3 kept after nmi ack", int_vector, 16'h0104);
    ack();
    chk("R9 nothing left", int_valid, 0);
    nmi_req = 1'b0; irq_req = '0;
    step();

    // disarm by a single write
    wr_narrow(16'h0012);
    chk("R3 narrow alone disarms", armed, 0);
    irq_req[0] = 1'b1;
    step();
    chk("R3 no delivery while disarmed", int_valid, 0);
    wr_narrow(16'h0034);
    chk("R3 same pointer again keeps disarmed", armed, 0);
    chk("R4 narrow value", sp_narrow, 16'h0034);
    wr_wide(16'h0123);
    chk("R3 rearmed by other pointer", armed, 1);
    chk("R10 held irq0 delivered", int_vector, 16'h0101);
    ack();
    irq_req = '0;
    wr_wide(16'h0100);
    chk("R3 wide alone disarms", armed, 0);
    sp_wide_we = 1'b1; sp_narrow_we = 1'b1;
    sp_wide_wdata = 16'h1234; sp_narrow_wdata = 16'hABCD;
    step();
    sp_wide_we = 1'b0; sp_narrow_we = 1'b0;
    chk("R2 joint write arms", armed, 1);
    chk("R4 joint wide", sp_wide, 16'h0234);
    chk("R4 joint narrow", sp_narrow, 16'h00CD);
    sp_wide_we = 1'b1; sp_narrow_we = 1'b1;
    step();
    sp_wide_we = 1'b0; sp_narrow_we = 1'b0;
    chk("R3 joint write keeps armed", armed, 1);

    // single sources
    for (int i = 0; i < 15; i++) begin
      irq_req[i] = 1'b1;
      step();
      chk("R7 single vector", int_vector, 32'h0101 + i);
      chk("R5 rise latched", int_valid, 1);
      ack();
      chk("R9 cleared after ack", int_valid, 0);
      step();
      chk("R5 held level no retrigger", int_valid, 0);
      irq_req[i] = 1'b0;
      step();
    end

    // ordered pairs
    for (int i = 0; i < 15; i++) begin
      for (int j = i + 1; j < 15; j++) begin
        irq_req[i] = 1'b1; irq_req[j] = 1'b1;
        step();
        chk("R7 lowest index wins", int_vector, 32'h0101 + i);
        ack();
        chk("R9 other kept", int_vector, 32'h0101 + j);
        ack();
        chk("R9 pair drained", int_valid, 0);
        irq_req = '0;
        step();
      end
    end

    // global enable
    gie = 1'b0;
    irq_req[5] = 1'b1;
    step();
    chk("R8 gie blocks maskable", int_valid, 0);
    nmi_req = 1'b1;
    step();
    chk("R8 nmi ignores gie", int_vector, 16'h0100);
    ack();
    chk("R8 maskable still blocked", int_valid, 0);
    gie = 1'b1;
    #1;
    chk("R8 maskable kept pending", int_vector, 16'h0106);
    ack();
    nmi_req = 1'b0; irq_req = '0;
    step();

    // nmi against each source
    for (int i = 0; i < 15; i++) begin
      nmi_req = 1'b1; irq_req[i] = 1'b1;
      step();
      chk("R6 nmi first", int_vector, 16'h0100);
      ack();
      chk("R9 maskable after nmi", int_vector, 32'h0101 + i);
      ack();
      chk("R9 drained", int_valid, 0);
      nmi_req = 1'b0; irq_req = '0;
      step();
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule